// File: doc/BRIEF.md
# Floating-Point Control and Status State

This block holds the floating-point control and status state of a core: a five-bit field of sticky exception flags and a three-bit rounding-mode field. Software reaches that state through three aliased addresses: one sees only the flags, one sees only the rounding mode, and one sees both packed into a single byte. Every software access is a swap. The block returns the old value of the addressed view in the same cycle and updates the state at the next clock edge. The update either writes the field, sets bits in it, or clears bits in it.

Arithmetic units report the exceptions they raise on a separate accrual input. Those bits are ORed into the sticky flags every cycle. When a software access and accrual land in the same cycle, the accrued bits are ORed on top of the result of the software access. Privilege checking and trapping on a reserved rounding mode are the job of the surrounding pipeline.

Top module: `fcsr_unit`

## Requirements
- R1: After reset all eight state bits are zero, so a read of the combined view (address 0x003) returns 0x00.
- R2: The combined view packs the flags in bits [4:0] and the rounding mode in bits [7:5]. Write data bits above bit 7 are discarded: writing 0x1234 stores 0x34.
- R3: Each access returns on `rd_data`, in the same cycle, the value the addressed view held before the access. The view is zero-extended to the data width.
- R4: The flags view (address 0x001) reads and modifies only bits [4:0]. With a combined value of 0x34 it reads 0x14.
- R5: The rounding-mode view (address 0x002) reads the mode in bits [2:0] and modifies only the mode. Writing 2 when the combined value is 0x34 returns 1 and leaves the combined value at 0x54.
- R6: The operation code selects the update. 1 writes the field, 2 ORs the masked write data into it, and 3 clears the masked bits (AND-NOT). Clearing mask 4 in the flags view at 0x54 returns 0x14 and leaves 0x50.
- R7: An access to any other address returns 0 and changes no state. An enable that is low, or operation code 0, also changes no state.
- R8: The `accrue` bits are ORed into the flags at each clock edge. Flag bit 4 is invalid operation and bit 0 is inexact. A flag that has been set stays set until software clears it.
- R9: When a software access and accrual happen in the same cycle, the stored flags are the software result ORed with the accrued bits.
- R10: The outputs `frm` and `fflags` always show the current stored fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Software access enable |
| acc_addr | input | 12 | View address |
| acc_op | input | 2 | 0 none, 1 write, 2 set bits, 3 clear bits |
| wr_data | input | 32 | Write data or bit mask |
| rd_data | output | 32 | Old value of the addressed view |
| accrue | input | 5 | Exception flags raised by arithmetic units |
| frm | output | 3 | Current rounding mode |
| fflags | output | 5 | Current sticky flags |

## Verification
The bench attacks the aliasing between views. A flags write that leaks into the mode field, or a mode write aimed at bits [4:0], shows up as a wrong combined readback. It drives set and clear masks that cover bits outside the addressed field; a design with poor masking then disturbs the neighbouring field. It collides accrual with a software clear of the same bit, where a design that lets software win loses the exception. It probes unmapped addresses and a low enable, where a loose decoder would return stale data or corrupt the state.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int FLAG_W = 5;
  localparam int MODE_W = 3;
  localparam int STATE_W = FLAG_W + MODE_W;
  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } fcsr_op_e;

  typedef enum logic [1:0] {
    VIEW_NONE = 2'd0,
    VIEW_FLAG = 2'd1,
    VIEW_MODE = 2'd2,
    VIEW_ALL  = 2'd3
  } fcsr_view_e;

  function automatic logic [STATE_W-1:0] apply_op(
    input fcsr_op_e op, input logic [STATE_W-1:0] cur, input logic [STATE_W-1:0] arg);
    case (op)
      OP_WRITE: apply_op = arg;
      OP_SET:   apply_op = cur | arg;
      OP_CLEAR: apply_op = cur & ~arg;
      default:  apply_op = cur;
    endcase
  endfunction
endpackage

// File: rtl/fcsr_decode.sv
module fcsr_decode
  import fcsr_pkg::*;
#(
  parameter logic [ADDR_W-1:0] FLAG_ADDR = 12'h001,
  parameter logic [ADDR_W-1:0] MODE_ADDR = 12'h002,
  parameter logic [ADDR_W-1:0] ALL_ADDR  = 12'h003
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output fcsr_view_e        view
);
  always_comb begin
    view = VIEW_NONE;
    if (en) begin
      if (addr == FLAG_ADDR)      view = VIEW_FLAG;
      else if (addr == MODE_ADDR) view = VIEW_MODE;
      else if (addr == ALL_ADDR)  view = VIEW_ALL;
    end
  end
endmodule

// File: rtl/fcsr_view.sv
module fcsr_view
  import fcsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fcsr_view_e         view,
  input  logic [STATE_W-1:0] state,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [STATE_W-1:0] field_mask,
  output logic [STATE_W-1:0] arg
);
  localparam logic [STATE_W-1:0] FLAG_MASK = STATE_W'((1 << FLAG_W) - 1);
  localparam logic [STATE_W-1:0] MODE_MASK = ~FLAG_MASK;

  always_comb begin
    rdata = '0;
    field_mask = '0;
    arg = '0;
    case (view)
      VIEW_FLAG: begin
        rdata = DATA_W'(state[FLAG_W-1:0]);
        field_mask = FLAG_MASK;
        arg = STATE_W'(wdata[FLAG_W-1:0]);
      end
      VIEW_MODE: begin
        rdata = DATA_W'(state[STATE_W-1:FLAG_W]);
        field_mask = MODE_MASK;
        arg = {wdata[MODE_W-1:0], {FLAG_W{1'b0}}};
      end
      VIEW_ALL: begin
        rdata = DATA_W'(state);
        field_mask = '1;
        arg = wdata[STATE_W-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        acc_op,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [FLAG_W-1:0] accrue,
  output logic [MODE_W-1:0] frm,
  output logic [FLAG_W-1:0] fflags
);
  logic [STATE_W-1:0] state_q, state_d, field_mask, arg, sw_val;
  fcsr_view_e view;
  fcsr_op_e   op;
  logic       upd_en;

  assign op = fcsr_op_e'(acc_op);

  fcsr_decode i_dec (.en(acc_en), .addr(acc_addr), .view(view));

  fcsr_view #(.DATA_W(DATA_W)) i_view (
    .view(view), .state(state_q), .wdata(wr_data),
    .rdata(rd_data), .field_mask(field_mask), .arg(arg));

  always_comb begin
    sw_val = (state_q & ~field_mask) |
             (apply_op(op, state_q, arg) & field_mask);
    state_d = sw_val | STATE_W'(accrue);
    upd_en  = (view != VIEW_NONE && op != OP_NONE) || (accrue != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      state_q <= '0;
    else if (upd_en) state_q <= state_d;
  end

  assign fflags = state_q[FLAG_W-1:0];
  assign frm    = state_q[STATE_W-1:FLAG_W];

  // Flags are sticky: an accrued bit is set after the edge (R8, R9)
  assert_accrue_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accrue != '0) |=> ((fflags & $past(accrue)) == $past(accrue)));

  // Without an access, a flag never falls
  assert_flags_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> ((fflags & $past(fflags)) == $past(fflags)));

  // Mode only changes through the mode or combined view
  assert_mode_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && (acc_addr == 12'h002 || acc_addr == 12'h003)) |=> $stable(frm));

  // Unmapped address reads zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_addr > 12'h003) |-> rd_data == '0);

  // Read data never wider than the state
  assert_rd_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:STATE_W] == '0);
endmodule

// File: tb/test_fcsr_unit.sv
module test_fcsr_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        acc_en = 0;
  logic [11:0] acc_addr = 0;
  logic [1:0]  acc_op = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [4:0]  accrue = 0;
  logic [2:0]  frm;
  logic [4:0]  fflags;
  int total = 0, bad = 0;
  logic [7:0] model;

  always #10 clk = ~clk;

  fcsr_unit i_fcsr_unit (.clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_addr(acc_addr),
    .acc_op(acc_op), .wr_data(wr_data), .rd_data(rd_data), .accrue(accrue),
    .frm(frm), .fflags(fflags));

  function automatic logic [7:0] fmask(input logic [11:0] a);
    case (a)
      12'h001: fmask = 8'h1f;
      12'h002: fmask = 8'he0;
      12'h003: fmask = 8'hff;
      default: fmask = 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] farg(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h001: farg = {3'b0, d[4:0]};
      12'h002: farg = {d[2:0], 5'b0};
      default: farg = d[7:0];
    endcase
  endfunction

  function automatic logic [31:0] fread(input logic [11:0] a, input logic [7:0] s);
    case (a)
      12'h001: fread = {27'b0, s[4:0]};
      12'h002: fread = {29'b0, s[7:5]};
      12'h003: fread = {24'b0, s};
      default: fread = 0;
    endcase
  endfunction

  function automatic logic [7:0] fnext(input logic en, input logic [11:0] a, input logic [1:0] op,
                                       input logic [31:0] d, input logic [4:0] acc, input logic [7:0] s);
    logic [7:0] m, g, n;
    m = en ? fmask(a) : 8'h00;
    g = farg(a, d);
    case (op)
      2'd1: n = g;
      2'd2: n = s | g;
      2'd3: n = s & ~g;
      default: n = s;
    endcase
    fnext = ((s & ~m) | (n & m)) | {3'b0, acc};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, check read at mid-low, state after posedge
  task automatic access(input string req, input logic en, input logic [11:0] a, input logic [1:0] op,
                        input logic [31:0] d, input logic [4:0] acc);
    @(negedge clk);
    acc_en = en; acc_addr = a; acc_op = op; wr_data = d; accrue = acc;
    #2;
    if (en) check({req, " rd"}, rd_data, fread(a, model));
    model = fnext(en, a, op, d, acc, model);
    @(posedge clk); #2;
    acc_en = 0; accrue = 0;
    check({req, " state"}, {24'b0, frm, fflags}, {24'b0, model});
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    model = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    access("R1", 1, 12'h003, 2'd0, 0, 0);
    // R2/R3 sequence
    access("R2", 1, 12'h003, 2'd1, 32'h1, 0);
    access("R3", 1, 12'h003, 2'd1, 32'h1234, 0);
    check("R3 old value", model, 8'h34);
    access("R4", 1, 12'h001, 2'd0, 0, 0);
    access("R5", 1, 12'h002, 2'd1, 32'h2, 0);
    check("R5 combined", model, 8'h54);
    access("R6", 1, 12'h001, 2'd3, 32'h4, 0);
    check("R6 combined", model, 8'h50);
    access("R6 set mode", 1, 12'h002, 2'd2, 32'hfffffff9, 0);
    access("R4 flags set wide", 1, 12'h001, 2'd2, 32'hffffffff, 0);
    // R7 unmapped, disabled
    access("R7 unmapped", 1, 12'h7ff, 2'd1, 32'h0, 0);
    access("R7 disabled", 0, 12'h003, 2'd1, 32'h0, 0);
    access("R7 nop op", 1, 12'h003, 2'd0, 32'h0, 0);
    // R8 accrual
    access("R6 clear all", 1, 12'h003, 2'd1, 32'h0, 0);
    access("R8 invalid", 0, 0, 0, 0, 5'h10);
    access("R8 inexact", 0, 0, 0, 0, 5'h01);
    check("R8 sticky", {27'b0, fflags}, 32'h11);
    // R9 collision: clear bit 4 while accruing it
    access("R9", 1, 12'h001, 2'd3, 32'h10, 5'h10);
    check("R9 kept", {31'b0, fflags[4]}, 1);
    // R10 random mix
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      a = ($urandom % 5 == 0) ? 12'($urandom) : 12'($urandom % 4);
      access("R10 random", 1'($urandom), a, 2'($urandom), $urandom, 5'($urandom % 3 == 0 ? $urandom : 0));
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule